// File: doc/BRIEF.md
# Presettable Split Decade Counter

This block is a four-bit decade counter made of two sections that are clocked separately. Bit 0 is a toggle stage that divides by two and is advanced by count input `cp0`. Bits 3..1 form a divide-by-five stage that is advanced by count input `cp1`. Each section moves on a HIGH-to-LOW transition of its own count input. A free-running system clock samples both count inputs through synchronizers and falling-edge detectors, so all of the state sits in ordinary clocked registers.

The two sections can run on their own, or a mode input can chain them inside the block. In one chained mode, bit 0 falling advances the divide-by-five stage, which gives plain BCD counting. In the other, bit 3 falling toggles bit 0, which gives a bi-quinary order in which bit 0 is a divide-by-ten output with a 50% duty cycle. An active-low master clear overrides everything. An active-low load copies the four data inputs into the state and acts as a transparent latch while it is held LOW.

Top module: `decade_split_counter`

## Requirements
- R1: While `mrN` is LOW, `q` is 0000, whatever the levels on `plN`, `pData`, `cp0` and `cp1`.
- R2: With `mrN` HIGH and `plN` LOW, `q` equals `pData` and follows every change of it. When `plN` returns HIGH, the last value is held and counting continues from it.
- R3: A count-input falling edge that is sampled while `plN` or `mrN` is LOW is discarded. After the override ends, `q` still shows the loaded or cleared value.
- R4: With chaining off, each falling edge of `cp0` toggles `q[0]` once, and the new value is visible no later than three system clocks after the edge. A rising edge of `cp0` changes nothing.
- R5: With chaining off, each falling edge of `cp1` steps `q[3:1]` through 000, 001, 010, 011, 100 and then back to 000. `q[0]` is left untouched.
- R6: An out-of-range value loaded into `q[3:1]` returns to the legal cycle on the next step: 101 goes to 010, 110 goes to 010, and 111 goes to 000.
- R7: With `chainEn`=1 and `chainSel`=0, each falling edge of `cp0` advances `q` through the BCD values 0 to 9 and then wraps to 0. A 1-to-0 change of `q[0]` steps the upper section in the same system cycle, and `cp1` is ignored.
- R8: With `chainEn`=1 and `chainSel`=1, each falling edge of `cp1` advances the upper section. A 1-to-0 change of `q[3]` toggles `q[0]` in the same cycle. After k edges from zero, `q[0]` = (k mod 10 >= 5) and `q[3:1]` = k mod 5. In this mode `cp0` is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples the count inputs |
| mrN | input | 1 | Master clear, active LOW, asynchronous |
| plN | input | 1 | Parallel load, active LOW, transparent while LOW |
| cp0 | input | 1 | Count input for the divide-by-two stage (falling edge) |
| cp1 | input | 1 | Count input for the divide-by-five stage (falling edge) |
| chainEn | input | 1 | 1 = the two sections are chained internally |
| chainSel | input | 1 | With chaining on: 0 = BCD (bit 0 feeds the upper section), 1 = bi-quinary (bit 3 feeds bit 0) |
| pData | input | 4 | Data to load |
| q | output | 4 | Counter state, with bit 0 being the divide-by-two stage |

## Verification
The assertions check these properties on every cycle:
- the clear override and the transparent-load override at the output;
- the rule that any change of the upper section is a legal single step from a legal state;
- the same-cycle ripple of the chained modes: bit 0 falling in BCD mode, and bit 3 falling in bi-quinary mode.

Only the bench scenarios can show the other behaviours:
- whole sequences, such as the BCD wrap from 9 to 0 and the ten-state bi-quinary order with its 50% duty bit;
- recovery from out-of-range loads;
- that count edges arriving during a load or a clear are lost;
- that the unused count input has no effect in each chained mode.

// File: rtl/dsc_pkg.sv
package dsc_pkg;

  localparam int STATE_W = 4;
  localparam int FIVE_W  = 3;

  typedef struct packed {
    logic stepTwo;   // toggle bit 0
    logic stepFive;  // advance bits 3..1
    logic load;      // copy parallel data
  } dscStrobe_t;

  function automatic logic [FIVE_W-1:0] nextFive(input logic [FIVE_W-1:0] cur);
    logic [FIVE_W-1:0] nxt;
    case (cur)
      3'd0:    nxt = 3'd1;
      3'd1:    nxt = 3'd2;
      3'd2:    nxt = 3'd3;
      3'd3:    nxt = 3'd4;
      3'd4:    nxt = 3'd0;
      3'd5:    nxt = 3'd2;
      3'd6:    nxt = 3'd2;
      default: nxt = 3'd0;
    endcase
    return nxt;
  endfunction

endpackage

// File: rtl/dsc_ctrl.sv
module dsc_ctrl
  import dsc_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int NUM_INPUTS  = 2
) (
  input  logic       clk,
  input  logic       mrN,
  input  logic       plN,
  input  logic       cp0,
  input  logic       cp1,
  input  logic       chainEn,
  input  logic       chainSel,
  input  logic       curQ0,
  input  logic       curQ3,
  output dscStrobe_t strobe
);

  localparam int MSB = SYNC_STAGES - 1;

  logic [NUM_INPUTS-1:0] cpIn;
  logic [NUM_INPUTS-1:0] fellEdge;

  assign cpIn = {cp1, cp0};

  // One synchronizer and one falling-edge detector for each count input.
  for (genvar gi = 0; gi < NUM_INPUTS; gi++) begin : g_edge
    logic [SYNC_STAGES-1:0] syncR;
    logic                   prevR;

    always_ff @(posedge clk or negedge mrN) begin
      if (!mrN) begin
        syncR <= '0;
        prevR <= 1'b0;
      end else begin
        syncR <= {syncR[MSB-1:0], cpIn[gi]};
        prevR <= syncR[MSB];
      end
    end

    assign fellEdge[gi] = prevR & ~syncR[MSB];
  end

  logic rawTwo;
  logic rawFive;

  // Internal chaining: the feeding bit's 1-to-0 change acts as a ripple
  // in the same cycle.
  always_comb begin
    rawTwo  = 1'b0;
    rawFive = 1'b0;
    if (!chainEn) begin
      rawTwo  = fellEdge[0];
      rawFive = fellEdge[1];
    end else if (!chainSel) begin
      rawTwo  = fellEdge[0];
      rawFive = fellEdge[0] & curQ0;
    end else begin
      rawFive = fellEdge[1];
      rawTwo  = fellEdge[1] & curQ3;
    end
  end

  always_comb begin
    strobe.load     = ~plN;
    strobe.stepTwo  = rawTwo & plN;
    strobe.stepFive = rawFive & plN;
  end

endmodule

// File: rtl/dsc_datapath.sv
module dsc_datapath
  import dsc_pkg::*;
(
  input  logic               clk,
  input  logic               mrN,
  input  dscStrobe_t         strobe,
  input  logic [STATE_W-1:0] pData,
  output logic [STATE_W-1:0] stateQ
);

  logic                twoR;
  logic [FIVE_W-1:0]   fiveR;

  always_ff @(posedge clk or negedge mrN) begin
    if (!mrN) begin
      twoR <= 1'b0;
    end else if (strobe.load) begin
      twoR <= pData[0];
    end else if (strobe.stepTwo) begin
      twoR <= ~twoR;
    end
  end

  always_ff @(posedge clk or negedge mrN) begin
    if (!mrN) begin
      fiveR <= '0;
    end else if (strobe.load) begin
      fiveR <= pData[STATE_W-1:1];
    end else if (strobe.stepFive) begin
      fiveR <= nextFive(fiveR);
    end
  end

  assign stateQ = {fiveR, twoR};

endmodule

// File: rtl/decade_split_counter.sv
module decade_split_counter
  import dsc_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       mrN,
  input  logic       plN,
  input  logic       cp0,
  input  logic       cp1,
  input  logic       chainEn,
  input  logic       chainSel,
  input  logic [3:0] pData,
  output logic [3:0] q
);

  dscStrobe_t         strobe;
  logic [STATE_W-1:0] stateQ;

  dsc_ctrl #(.SYNC_STAGES(SYNC_STAGES), .NUM_INPUTS(2)) u_ctrl (
    .clk      (clk),
    .mrN      (mrN),
    .plN      (plN),
    .cp0      (cp0),
    .cp1      (cp1),
    .chainEn  (chainEn),
    .chainSel (chainSel),
    .curQ0    (stateQ[0]),
    .curQ3    (stateQ[STATE_W-1]),
    .strobe   (strobe)
  );

  dsc_datapath u_dp (
    .clk    (clk),
    .mrN    (mrN),
    .strobe (strobe),
    .pData  (pData),
    .stateQ (stateQ)
  );

  // Clear and load act on the output immediately.
  always_comb begin
    if (!mrN)      q = '0;
    else if (!plN) q = pData;
    else           q = stateQ;
  end

endmodule

// File: rtl/dsc_checker.sv
module dsc_checker (
  input logic       clk,
  input logic       mrN,
  input logic       plN,
  input logic       cp0,
  input logic       cp1,
  input logic       chainEn,
  input logic       chainSel,
  input logic [3:0] pData,
  input logic [3:0] q
);

  AST_CLEAR_ZERO: assert property (@(posedge clk)
    !mrN |-> q == 4'd0); // R1

  AST_LOAD_TRACK: assert property (@(posedge clk) disable iff (!mrN)
    !plN |-> q == pData); // R2

  AST_FIVE_STEP: assert property (@(posedge clk) disable iff (!mrN)
    (plN && $past(plN) && $past(q[3:1]) < 3'd5 && q[3:1] != $past(q[3:1]))
    |-> q[3:1] == (($past(q[3:1]) == 3'd4) ? 3'd0 : $past(q[3:1]) + 3'd1)); // R5

  AST_BCD_RIPPLE: assert property (@(posedge clk) disable iff (!mrN)
    (plN && $past(plN) && chainEn && !chainSel && $past(chainEn) && !$past(chainSel)
     && $fell(q[0])) |-> q[3:1] != $past(q[3:1])); // R7

  AST_BIQ_RIPPLE: assert property (@(posedge clk) disable iff (!mrN)
    (plN && $past(plN) && chainEn && chainSel && $past(chainEn) && $past(chainSel)
     && $fell(q[3])) |-> q[0] != $past(q[0])); // R8

endmodule

bind decade_split_counter dsc_checker u_chk (.*);

// File: tb/sim_decade_split_counter.sv
`timescale 1ns/1ps
module sim_decade_split_counter;

  logic       clk = 1'b0;
  logic       mrN = 1'b0;
  logic       plN = 1'b1;
  logic       cp0 = 1'b1;
  logic       cp1 = 1'b1;
  logic       chainEn = 1'b0;
  logic       chainSel = 1'b0;
  logic [3:0] pData = 4'd0;
  logic [3:0] q;

  int checks = 0;
  int fails  = 0;
  int cycles = 0;
  bit done   = 1'b0;

  always #2 clk = ~clk;

  decade_split_counter u0 (
    .clk(clk), .mrN(mrN), .plN(plN), .cp0(cp0), .cp1(cp1),
    .chainEn(chainEn), .chainSel(chainSel), .pData(pData), .q(q)
  );

  task automatic check(input string req, input logic [3:0] exp);
    @(negedge clk);
    checks++;
    if (q !== exp) begin
      fails++;
      $display("FAIL %s: q=%b expected %b", req, q, exp);
    end
  endtask

  task automatic pulse(input int which);
    @(negedge clk);
    if (which == 0) cp0 = 1'b0; else cp1 = 1'b0;
    repeat (4) @(negedge clk);
    if (which == 0) cp0 = 1'b1; else cp1 = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  task automatic doLoad(input logic [3:0] v);
    @(negedge clk);
    plN = 1'b0; pData = v;
    repeat (3) @(negedge clk);
    plN = 1'b1;
  endtask

  task automatic doClear();
    @(negedge clk);
    mrN = 1'b0;
    repeat (2) @(negedge clk);
    mrN = 1'b1;
  endtask

  task automatic testReset();
    check("R1", 4'd0);
    plN = 1'b0; pData = 4'hF;
    check("R1", 4'd0);
    plN = 1'b1;
    pulse(0);
    check("R1", 4'd0);
    mrN = 1'b1;
    check("R1", 4'd0);
  endtask

  task automatic testDivTwo();
    chainEn = 1'b0;
    doClear();
    @(negedge clk); cp0 = 1'b0;
    repeat (3) @(posedge clk);
    check("R4", 4'd1);
    cp0 = 1'b1;
    repeat (4) @(negedge clk);
    check("R4", 4'd1);
    pulse(0);
    check("R4", 4'd0);
  endtask

  task automatic testDivFive();
    chainEn = 1'b0;
    doClear();
    for (int k = 1; k <= 5; k++) begin
      pulse(1);
      check("R5", 4'((k % 5) << 1));
    end
  endtask

  task automatic testLoad();
    @(negedge clk);
    plN = 1'b0; pData = 4'd6;
    check("R2", 4'd6);
    pData = 4'd9;
    check("R2", 4'd9);
    repeat (2) @(negedge clk);
    plN = 1'b1;
    check("R2", 4'd9);
    pulse(0);
    check("R2", 4'd8);
  endtask

  task automatic testDiscard();
    chainEn = 1'b0;
    @(negedge clk);
    plN = 1'b0; pData = 4'd3;
    pulse(0);
    pulse(1);
    plN = 1'b1;
    check("R3", 4'd3);
    @(negedge clk);
    mrN = 1'b0;
    pulse(1);
    mrN = 1'b1;
    repeat (4) @(negedge clk);
    check("R3", 4'd0);
  endtask

  task automatic testIllegal();
    chainEn = 1'b0;
    doLoad(4'hA); pulse(1); check("R6", 4'h4);
    doLoad(4'hC); pulse(1); check("R6", 4'h4);
    doLoad(4'hF); pulse(1); check("R6", 4'h1);
  endtask

  task automatic testBcd();
    chainEn = 1'b1; chainSel = 1'b0;
    doClear();
    for (int k = 1; k <= 11; k++) begin
      pulse(0);
      check("R7", 4'(k % 10));
    end
    pulse(1);
    check("R7", 4'd1);
  endtask

  task automatic testBiq();
    chainEn = 1'b1; chainSel = 1'b1;
    doClear();
    for (int k = 1; k <= 10; k++) begin
      logic [3:0] e;
      e = {3'(k % 5), ((k % 10) >= 5) ? 1'b1 : 1'b0};
      pulse(1);
      check("R8", e);
    end
    pulse(1);
    pulse(0);
    check("R8", 4'h2);
  endtask

  task automatic finishRun();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000 && !done) begin
      done = 1'b1;
      checks++; fails++;
      $display("FAIL watchdog: cycles=%0d expected completion", cycles);
      finishRun();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    testReset();
    testDivTwo();
    testDivFive();
    testLoad();
    testDiscard();
    testIllegal();
    testBcd();
    testBiq();
    done = 1'b1;
    finishRun();
  end

endmodule